// File: doc/BRIEF.md
# Offset Color Space Matrix

This block converts one three-channel pixel per clock with a programmable 3x3 matrix, for example from RGB to limited-range YCbCr on 10-bit video. A signed offset is added to each input channel before the matrix, and a second signed offset is added to each result row after it. Between the two, every row is accumulated at full precision, rounded, scaled down so that a coefficient of 1024 means unity gain, and then shifted right by a programmable amount. The result is saturated to the 10-bit range.

Software programs coefficients, offsets, a shift amount and an enable bit through a 32-bit write port, two fields per word. With the enable bit clear the pixel is passed through untouched. Pixels always take three cycles from input to output. Each pixel carries the configuration that was in force when it entered, so reprogramming never corrupts a pixel that is already in flight.

Top module: `csc_matrix`

## Requirements
- R1: After reset every coefficient, offset, the shift and the enable are zero, `out_valid` is low and `out_pix` is zero; pixels sent before any write come out unchanged.
- R2: Each pixel accepted with `in_valid` high appears with `out_valid` high exactly 3 clock edges later, one output per input, in order; `out_valid` is never high otherwise.
- R3: When the enable bit (address 9, bit 0) is clear at a pixel's entry, its output equals its input bit for bit.
- R4: Channel c of a pixel is bits [10c+9:10c]. With the enable set, output row r is clip(((S + 512) >>> 10) >>> sh + post_r), where S = sum over j of coef_rj * (x_j + pre_j), and `>>>` is an arithmetic shift.
- R5: Coefficients are 13-bit two's complement. coef_rj has index k = 3r+j and is written at address 2 + k/2. An even k is taken from bits 28:16 and an odd k from bits 12:0, so coef22 alone sits in bits 28:16 of address 6.
- R6: Offsets are 12-bit two's complement. Pre-offsets are written at address 0 (channel 0 in bits 27:16, channel 1 in bits 11:0) and address 1 (channel 2 in bits 11:0). Post-offsets use the same layout at addresses 7 and 8.
- R7: The shift amount is bits 18:16 of address 10, values 0 to 7.
- R8: A row result below 0 gives 0, and one above 1023 gives 1023.
- R9: A write takes effect for the first pixel accepted on a later clock edge than the write. Pixels accepted on or before that edge use the old values for the whole of their path.
- R10: Writes to addresses 11 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_pix | input | 30 | Input pixel, channel c in bits [10c+9:10c] |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 30 | Output pixel, same channel layout |

## Verification
The hardest case to reach from the ports is a register write that lands while several pixels are in different pipeline stages, each of which must finish with the configuration it entered under. The stimulus streams pixels back to back while it writes random words to random addresses on the same cycles. A reference model takes a snapshot of its shadow configuration as each pixel is accepted. Directed sets of coefficients drive rows past both saturation limits and step through every shift value.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int DW    = 10;  // bits per channel
  localparam int CW    = 13;  // coefficient width
  localparam int OW    = 12;  // offset width
  localparam int SHW   = 3;   // shift field width
  localparam int FRAC  = 10;  // coefficient fraction bits (1024 = 1.0)
  localparam int NCH   = 3;   // channels
  localparam int ADW   = 4;   // register address width
  localparam int HI    = 16;  // bit position of the upper field in a word
  localparam int NCOEF = NCH * NCH;

  localparam int XW = ((DW + 1 > OW) ? DW + 1 : OW) + 1;  // pre-offset sum
  localparam int PW = XW + CW;                             // one product
  localparam int AW = PW + $clog2(NCH);                    // row accumulator
  localparam int SW = AW - FRAC + 1;                       // scaled + post

  localparam int A_PRE   = 0;
  localparam int A_COEF  = 2;
  localparam int A_POST  = 7;
  localparam int A_CTRL  = 9;
  localparam int A_MODE  = 10;
  localparam int A_LAST  = 10;

  typedef struct packed {
    logic [NCOEF*CW-1:0] coef;
    logic [NCH*OW-1:0]   post;
    logic [SHW-1:0]      shift;
    logic                en;
  } csc_cfg_t;
endpackage

// File: rtl/csc_regs.sv
module csc_regs
  import csc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [ADW-1:0]   cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [NCH*OW-1:0] pre_flat,
  output csc_cfg_t         cfg
);
  logic [NCOEF*CW-1:0] coef_d, coef_q;
  logic [NCH*OW-1:0]   pre_d, pre_q, post_d, post_q;
  logic [SHW-1:0]      sh_d, sh_q;
  logic                en_d, en_q;

  always_comb begin
    coef_d = coef_q;
    pre_d  = pre_q;
    post_d = post_q;
    sh_d   = sh_q;
    en_d   = en_q;
    if (cfg_we) begin
      for (int k = 0; k < NCOEF; k++) begin
        if (cfg_addr == ADW'(A_COEF + k / 2))
          coef_d[k*CW +: CW] = (k % 2 == 0) ? cfg_wdata[HI +: CW] : cfg_wdata[0 +: CW];
      end
      for (int c = 0; c < NCH; c++) begin
        if (cfg_addr == ADW'(A_PRE + c / 2))
          pre_d[c*OW +: OW] = (c % 2 == 0 && c + 1 < NCH) ? cfg_wdata[HI +: OW] : cfg_wdata[0 +: OW];
        if (cfg_addr == ADW'(A_POST + c / 2))
          post_d[c*OW +: OW] = (c % 2 == 0 && c + 1 < NCH) ? cfg_wdata[HI +: OW] : cfg_wdata[0 +: OW];
      end
      if (cfg_addr == ADW'(A_CTRL)) en_d = cfg_wdata[0];
      if (cfg_addr == ADW'(A_MODE)) sh_d = cfg_wdata[HI +: SHW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_q <= '0;
      pre_q  <= '0;
      post_q <= '0;
      sh_q   <= '0;
      en_q   <= 1'b0;
    end else if (cfg_we) begin
      coef_q <= coef_d;
      pre_q  <= pre_d;
      post_q <= post_d;
      sh_q   <= sh_d;
      en_q   <= en_d;
    end
  end

  assign pre_flat  = pre_q;
  assign cfg.coef  = coef_q;
  assign cfg.post  = post_q;
  assign cfg.shift = sh_q;
  assign cfg.en    = en_q;

  // R10: writes outside the map leave all state untouched
  assert_unused_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr > ADW'(A_LAST)) |=> ($stable(coef_q) && $stable(pre_q) &&
      $stable(post_q) && $stable(sh_q) && $stable(en_q)));

  // R3: the enable bit follows bit 0 of a control write
  assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADW'(A_CTRL)) |=> (en_q == $past(cfg_wdata[0])));
endmodule

// File: rtl/csc_row.sv
module csc_row
  import csc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_acc,
  input  logic                ld_out,
  input  logic [NCH*XW-1:0]   x_flat,
  input  logic [NCH*CW-1:0]   coef_row,
  input  logic [SHW-1:0]      shift,
  input  logic [OW-1:0]       post,
  input  logic                conv_en,
  input  logic [DW-1:0]       raw,
  output logic [DW-1:0]       y
);
  localparam int HALF = 1 << (FRAC - 1);
  localparam int MAXV = (1 << DW) - 1;

  logic signed [AW-1:0] acc_d, acc_q, rnd, scl;
  logic signed [SW-1:0] sum;
  logic [DW-1:0]        clipped, y_d;

  always_comb begin
    acc_d = '0;
    for (int j = 0; j < NCH; j++)
      acc_d = acc_d + AW'($signed(x_flat[j*XW +: XW])) * AW'($signed(coef_row[j*CW +: CW]));
  end

  always_comb begin
    rnd = acc_q + AW'(HALF);
    scl = (rnd >>> FRAC) >>> shift;
    sum = SW'(scl) + SW'($signed(post));
    if (sum < 0)                clipped = '0;
    else if (sum > SW'(MAXV))   clipped = '1;
    else                        clipped = sum[DW-1:0];
    y_d = conv_en ? clipped : raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (ld_acc) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      y <= '0;
    else if (ld_out) y <= y_d;
  end

  // R8: saturation at both ends of the range
  assert_clip_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_out && conv_en && sum < 0) |=> (y == '0));
  assert_clip_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_out && conv_en && sum > SW'(MAXV)) |=> (y == DW'(MAXV)));
endmodule

// File: rtl/csc_matrix.sv
module csc_matrix
  import csc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              in_valid,
  input  logic [29:0]       in_pix,
  output logic              out_valid,
  output logic [29:0]       out_pix
);
  logic [NCH*OW-1:0] pre_flat;
  csc_cfg_t          cfg_live;

  csc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pre_flat(pre_flat), .cfg(cfg_live)
  );

  // stage 1: pre-offset, configuration snapshot
  logic [NCH*XW-1:0] x1_d, x1_q;
  logic [NCH*DW-1:0] raw1_q, raw2_q;
  csc_cfg_t          cfg1_q;
  logic              v1_q, v2_q, v3_q;
  logic [NCH*OW-1:0] post2_q;
  logic [SHW-1:0]    sh2_q;
  logic              en2_q;

  always_comb begin
    for (int c = 0; c < NCH; c++)
      x1_d[c*XW +: XW] = XW'($signed({1'b0, in_pix[c*DW +: DW]})) +
                         XW'($signed(pre_flat[c*OW +: OW]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1_q   <= '0;
      raw1_q <= '0;
      cfg1_q <= '0;
    end else if (in_valid) begin
      x1_q   <= x1_d;
      raw1_q <= in_pix;
      cfg1_q <= cfg_live;
    end
  end

  // stage 2 snapshot for the final stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw2_q  <= '0;
      post2_q <= '0;
      sh2_q   <= '0;
      en2_q   <= 1'b0;
    end else if (v1_q) begin
      raw2_q  <= raw1_q;
      post2_q <= cfg1_q.post;
      sh2_q   <= cfg1_q.shift;
      en2_q   <= cfg1_q.en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= in_valid;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  for (genvar r = 0; r < NCH; r++) begin : g_row
    csc_row u_row (
      .clk(clk), .rst_n(rst_n), .ld_acc(v1_q), .ld_out(v2_q),
      .x_flat(x1_q), .coef_row(cfg1_q.coef[r*NCH*CW +: NCH*CW]),
      .shift(sh2_q), .post(post2_q[r*OW +: OW]), .conv_en(en2_q),
      .raw(raw2_q[r*DW +: DW]), .y(out_pix[r*DW +: DW])
    );
  end

  assign out_valid = v3_q;

  // R2: an output is only produced for a pixel accepted three edges before
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));

  // R3: bypass returns the captured input unchanged
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (v2_q && !en2_q) |=> (out_pix == $past(raw2_q)));

  // R9: the snapshot only changes when a pixel is accepted
  assert_snapshot_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cfg1_q));
endmodule

// File: tb/test_csc_matrix.sv
module test_csc_matrix;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        in_valid;
  logic [29:0] in_pix;
  logic        out_valid;
  logic [29:0] out_pix;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // shadow configuration, as defined by R5..R7, R3
  int s_pre[3], s_post[3], s_coef[9], s_sh, s_en;

  logic [29:0] exp_q[$];
  int          cyc_q[$];
  string       tag_q[$];

  csc_matrix i_csc_matrix (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_pix(in_pix),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sx12(logic [11:0] v);
    return int'($signed(v));
  endfunction
  function automatic int sx13(logic [12:0] v);
    return int'($signed(v));
  endfunction

  function automatic void shadow_reset();
    for (int i = 0; i < 3; i++) begin s_pre[i] = 0; s_post[i] = 0; end
    for (int i = 0; i < 9; i++) s_coef[i] = 0;
    s_sh = 0; s_en = 0;
  endfunction

  function automatic void shadow_write(logic [3:0] a, logic [31:0] d);
    case (a)
      4'd0: begin s_pre[0] = sx12(d[27:16]); s_pre[1] = sx12(d[11:0]); end
      4'd1: s_pre[2] = sx12(d[11:0]);
      4'd2, 4'd3, 4'd4, 4'd5: begin
        s_coef[2*(a-2)] = sx13(d[28:16]); s_coef[2*(a-2)+1] = sx13(d[12:0]);
      end
      4'd6: s_coef[8] = sx13(d[28:16]);
      4'd7: begin s_post[0] = sx12(d[27:16]); s_post[1] = sx12(d[11:0]); end
      4'd8: s_post[2] = sx12(d[11:0]);
      4'd9: s_en = int'(d[0]);
      4'd10: s_sh = int'(d[18:16]);
      default: ;  // R10: no effect
    endcase
  endfunction

  function automatic logic [29:0] model(logic [29:0] p);
    logic [29:0] r;
    if (s_en == 0) return p;
    for (int row = 0; row < 3; row++) begin
      int acc, v;
      acc = 0;
      for (int j = 0; j < 3; j++)
        acc += (int'(p[j*10 +: 10]) + s_pre[j]) * s_coef[row*3 + j];
      v = ((acc + 512) >>> 10) >>> s_sh;
      v = v + s_post[row];
      if (v < 0) v = 0;
      if (v > 1023) v = 1023;
      r[row*10 +: 10] = v[9:0];
    end
    return r;
  endfunction

  task automatic step(bit we, logic [3:0] a, logic [31:0] d, bit iv, logic [29:0] p, string tag);
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = d; in_valid = iv; in_pix = p;
    if (iv) begin
      exp_q.push_back(model(p));
      cyc_q.push_back(cyc);
      tag_q.push_back(tag);
    end
    if (we) shadow_write(a, d);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    step(1'b1, a, d, 1'b0, '0, "");
  endtask

  task automatic pix(logic [29:0] p, string tag);
    step(1'b0, 4'd0, 32'd0, 1'b1, p, tag);
  endtask

  function automatic logic [31:0] pair13(int hi, int lo);
    logic [12:0] h, l;
    h = hi[12:0]; l = lo[12:0];
    return {3'b0, h, 3'b0, l};
  endfunction
  function automatic logic [31:0] pair12(int hi, int lo);
    logic [11:0] h, l;
    h = hi[11:0]; l = lo[11:0];
    return {4'b0, h, 4'b0, l};
  endfunction

  task automatic set_coefs(int c0, int c1, int c2, int c3, int c4, int c5, int c6, int c7, int c8);
    wr(4'd2, pair13(c0, c1));
    wr(4'd3, pair13(c2, c3));
    wr(4'd4, pair13(c4, c5));
    wr(4'd5, pair13(c6, c7));
    wr(4'd6, pair13(c8, 0));
  endtask

  task automatic set_offsets(int p0, int p1, int p2, int q0, int q1, int q2);
    wr(4'd0, pair12(p0, p1));
    wr(4'd1, pair12(0, p2));
    wr(4'd7, pair12(q0, q1));
    wr(4'd8, pair12(0, q2));
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) step(1'b0, 4'd0, 32'd0, 1'b0, '0, "");
  endtask

  function automatic logic [29:0] rpix();
    return {10'($urandom_range(0, 1023)), 10'($urandom_range(0, 1023)), 10'($urandom_range(0, 1023))};
  endfunction

  // output checker, samples 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n && out_valid) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R2: unexpected output act=%h exp=none", out_pix);
        end else begin
          logic [29:0] e;
          int c0;
          string t;
          e = exp_q.pop_front(); c0 = cyc_q.pop_front(); t = tag_q.pop_front();
          if (out_pix !== e) begin
            bad++;
            $display("FAIL %s: pixel act=%h exp=%h", t, out_pix, e);
          end else if (cyc != c0 + 3) begin
            bad++;
            $display("FAIL R2: latency act=%0d exp=3", cyc - c0);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd2024);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_pix = '0;
    shadow_reset();
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || out_pix !== '0) begin
      bad++;
      $display("FAIL R1: reset outputs act=%b/%h exp=0/0", out_valid, out_pix);
    end

    // R1, R3: bypass after reset
    pix(30'h3FFFFFFF, "R1");
    pix(30'h0, "R1");
    for (int i = 0; i < 10; i++) pix(rpix(), "R3");
    drain();

    // R4: unity matrix
    set_coefs(1024, 0, 0, 0, 1024, 0, 0, 0, 1024);
    wr(4'd9, 32'h1);
    for (int i = 0; i < 10; i++) pix(rpix(), "R4");
    pix(30'h3FFFFFFF, "R4");
    drain();

    // R6: signed pre and post offsets
    set_offsets(-37, 100, 2047, 55, -2048, -1);
    for (int i = 0; i < 12; i++) pix(rpix(), "R6");
    drain();

    // R5, R4: RGB to limited YCbCr coefficients, 10-bit offsets
    set_offsets(0, 0, 0, 64, 512, 512);
    set_coefs(186, 627, 63, -102, -344, 448, 448, -406, -40);
    pix(30'h3FFFFFFF, "R5");
    pix(30'h0, "R5");
    pix({10'd0, 10'd0, 10'd1023}, "R5");
    pix({10'd1023, 10'd0, 10'd0}, "R5");
    for (int i = 0; i < 12; i++) pix(rpix(), "R5");
    drain();

    // R8: saturation high and low
    set_offsets(0, 0, 0, 0, 0, 0);
    set_coefs(4095, 4095, 4095, -4096, -4096, -4096, 4095, -4096, 0);
    pix(30'h3FFFFFFF, "R8");
    pix({10'd0, 10'd512, 10'd1}, "R8");
    set_offsets(-2048, 2047, 0, 2047, -2048, 0);
    pix(30'h0, "R8");
    pix(30'h3FFFFFFF, "R8");
    for (int i = 0; i < 6; i++) pix(rpix(), "R8");
    drain();

    // R7: every shift amount
    set_offsets(10, -20, 30, 40, 0, -5);
    set_coefs(2000, -300, 150, 500, 1024, 700, -800, 1500, 2047);
    for (int s = 0; s < 8; s++) begin
      wr(4'd10, 32'(s) << 16);
      pix(rpix(), "R7");
      pix(30'h3FFFFFFF, "R7");
    end
    drain();

    // R10: unused addresses write random data while pixels stream
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 4'($urandom_range(11, 15)), $urandom(), 1'b1, rpix(), "R10");
    end
    drain();

    // R9: writes to random registers on the same cycles as pixels
    for (int i = 0; i < 300; i++) begin
      bit we, iv;
      logic [31:0] d;
      logic [3:0] a;
      we = ($urandom_range(0, 3) != 0);
      iv = ($urandom_range(0, 4) != 0);
      a = 4'($urandom_range(0, 10));
      d = $urandom();
      if (a == 4'd9 && $urandom_range(0, 3) != 0) d[0] = 1'b1;
      step(we, a, d, iv, rpix(), "R9");
    end
    drain();

    // R3: disable after conversion
    wr(4'd9, 32'hFFFF_FFFE);
    for (int i = 0; i < 10; i++) pix(rpix(), "R3");
    drain();

    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R2: missing outputs act=%0d exp=0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule